// File: doc/BRIEF.md
# Shared Level-2 Cache Bus Arbiter

This block sits between the level-1 caches of a small multiprocessor cluster and the single 128-bit transaction bus that leads to the shared level-2 cache. Each CPU has two request ports: one for instruction fetches and one for data accesses. The arbiter admits exactly one transaction at a time. It forwards the address, write flag, write data and byte enables of the winner to the level-2 bus. It then steers the level-2 response back to that winner alone.

Arbitration has two tiers. Any pending instruction fetch wins over every data request. Within a tier, a round-robin search picks the CPU. The search starts at a rotation pointer, and that pointer moves to the CPU index just past each served CPU.

When the level-2 bus accepts a data write, the arbiter sends a one-cycle invalidate strobe and the write address to the data cache of every other CPU. This keeps write-through level-1 data caches coherent. Writes are serialised through the arbiter, so all CPUs see the invalidates in the same order as the writes.

All request paths use valid/ready. A requester raises valid with a stable payload and must hold both until it sees ready. The arbiter raises ready in the cycle that the level-2 bus takes the transfer. Toward the level-2 bus, the arbiter holds `l2_req_valid` and the whole payload steady until `l2_req_ready` is seen. The level-2 side signals completion with a one-cycle `l2_rsp_valid`, which it may raise no earlier than the cycle after acceptance; it can never be stalled. The snoop outputs are plain strobes with no back-pressure.

Top module: `cbarb_top`

## Requirements
- R1: Only one transaction is outstanding. After `l2_req_valid && l2_req_ready`, `l2_req_valid` stays low, and no requester gets ready, until the cycle after `l2_rsp_valid`. This holds even if new requests arrive in the meantime.
- R2: When the arbiter chooses a winner, any asserted `i_valid` bit wins over all `d_valid` bits.
- R3: Within the chosen tier, the winner is the first requesting CPU found by counting upward, with wrap, from the rotation pointer. The pointer is 0 after reset. When a transaction completes, the pointer is set to (winner index + 1) mod NCPU.
- R4: A requester's ready bit (`i_ready[c]` or `d_ready[c]`) is high only for the granted requester, and only in the cycle that the level-2 bus accepts. All other ready bits stay low.
- R5: While `l2_req_valid` is high and `l2_req_ready` is low, `l2_req_valid` remains high in the next cycle. `l2_addr` and `l2_write` also remain unchanged.
- R6: For a data winner, `l2_addr`, `l2_write`, `l2_wdata` and `l2_be` equal that CPU's data request fields. For an instruction winner, `l2_addr` is its fetch address and `l2_write` is 0.
- R7: In the cycle that `l2_rsp_valid` is high, exactly one response strobe is high: `i_rsp_valid[c]` for an instruction winner, or `d_rsp_valid[c]` for a data winner. `rsp_rdata` equals `l2_rsp_rdata`.
- R8: When the level-2 bus accepts a data write from CPU w, then in the next cycle `snoop_valid` has every bit except bit w set, and `snoop_addr` is the write address. In the cycle after that, `snoop_valid` is zero. Reads and instruction fetches leave `snoop_valid` at zero.
- R9: During and directly after reset, `l2_req_valid`, all ready bits, all response strobes and `snoop_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | NCPU | Instruction fetch request per CPU |
| i_ready | output | NCPU | Fetch request taken |
| i_addr | input | NCPU*AW | Fetch addresses, CPU c at bits [c*AW +: AW] |
| d_valid | input | NCPU | Data request per CPU |
| d_ready | output | NCPU | Data request taken |
| d_write | input | NCPU | 1 = write, 0 = read, per CPU |
| d_addr | input | NCPU*AW | Data addresses |
| d_wdata | input | NCPU*DW | Data write lines |
| d_be | input | NCPU*BEW | Data byte enables |
| i_rsp_valid | output | NCPU | Fetch response strobe per CPU |
| d_rsp_valid | output | NCPU | Data response strobe per CPU |
| rsp_rdata | output | DW | Response line shared by all requesters |
| l2_req_valid | output | 1 | Transaction offered to level 2 |
| l2_req_ready | input | 1 | Level 2 takes the transaction |
| l2_addr | output | AW | Transaction address |
| l2_write | output | 1 | Transaction is a write |
| l2_wdata | output | DW | Write line |
| l2_be | output | BEW | Byte enables |
| l2_rsp_valid | input | 1 | Level 2 completion strobe |
| l2_rsp_rdata | input | DW | Level 2 response line |
| snoop_valid | output | NCPU | Invalidate strobe per data cache |
| snoop_addr | output | AW | Address to invalidate |

## Verification
The invalidate broadcast for a write and the completion of that same write can land in the same cycle. This happens when the level-2 responder answers one cycle after acceptance. The arbiter must then assert the peer snoop strobes and the writer's `d_rsp_valid` together, without dropping either. The bench runs a part of its vector walk with a one-cycle response latency to force this overlap. In that cycle it checks the snoop mask, the snoop address, the routed response strobe and the response data.

In a second case, a fetch request is raised while a data write is still outstanding. The bench confirms that the fetch waits and that the data writer gets the completion.

// File: rtl/cbarb_pkg.sv
package cbarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/cbarb_rr_pick.sv
module cbarb_rr_pick #(
  parameter int NCPU = 4,
  parameter int IDW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] req,
  input  logic [IDW-1:0]  start,
  output logic            found,
  output logic [IDW-1:0]  idx
);
  // Scan offsets from far to near so the nearest requester overwrites last.
  always_comb begin
    logic [IDW-1:0] cand;
    found = |req;
    idx   = start;
    for (int k = NCPU - 1; k >= 0; k--) begin
      cand = start + IDW'(k);
      if (req[cand]) idx = cand;
    end
  end

  p_pick_real_r3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[idx]);
  p_pick_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req[start] |-> (idx == start));
endmodule

// File: rtl/cbarb_mux.sv
module cbarb_mux #(
  parameter int NCPU = 4,
  parameter int AW   = 32,
  parameter int DW   = 128,
  parameter int BEW  = DW / 8,
  parameter int IDW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [IDW-1:0]     gnt_idx,
  input  logic               gnt_instr,
  input  logic [NCPU*AW-1:0] i_addr,
  input  logic [NCPU-1:0]    d_write,
  input  logic [NCPU*AW-1:0] d_addr,
  input  logic [NCPU*DW-1:0] d_wdata,
  input  logic [NCPU*BEW-1:0] d_be,
  output logic [AW-1:0]      addr,
  output logic               write,
  output logic [DW-1:0]      wdata,
  output logic [BEW-1:0]     be
);
  always_comb begin
    if (gnt_instr) begin
      addr  = i_addr[gnt_idx*AW +: AW];
      write = 1'b0;
      wdata = '0;
      be    = '1;
    end else begin
      addr  = d_addr[gnt_idx*AW +: AW];
      write = d_write[gnt_idx];
      wdata = d_wdata[gnt_idx*DW +: DW];
      be    = d_be[gnt_idx*BEW +: BEW];
    end
  end
endmodule

// File: rtl/cbarb_snoop.sv
module cbarb_snoop #(
  parameter int NCPU = 4,
  parameter int AW   = 32,
  parameter int IDW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [IDW-1:0]  writer,
  input  logic [AW-1:0]   addr,
  output logic [NCPU-1:0] snoop_valid,
  output logic [AW-1:0]   snoop_addr
);
  for (genvar c = 0; c < NCPU; c++) begin : g_peer
    always_ff @(posedge clk) begin
      if (!rst_n) snoop_valid[c] <= 1'b0;
      else        snoop_valid[c] <= fire && (writer != IDW'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    snoop_addr <= '0;
    else if (fire) snoop_addr <= addr;
  end

  p_snoop_peers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|snoop_valid) |-> ($countones(snoop_valid) == NCPU - 1));
  p_snoop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|snoop_valid) |=> (snoop_valid == '0));
endmodule

// File: rtl/cbarb_top.sv
module cbarb_top #(
  parameter int NCPU = 4,
  parameter int AW   = 32,
  parameter int DW   = 128,
  parameter int BEW  = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCPU-1:0]    i_valid,
  output logic [NCPU-1:0]    i_ready,
  input  logic [NCPU*AW-1:0] i_addr,
  input  logic [NCPU-1:0]    d_valid,
  output logic [NCPU-1:0]    d_ready,
  input  logic [NCPU-1:0]    d_write,
  input  logic [NCPU*AW-1:0] d_addr,
  input  logic [NCPU*DW-1:0] d_wdata,
  input  logic [NCPU*BEW-1:0] d_be,
  output logic [NCPU-1:0]    i_rsp_valid,
  output logic [NCPU-1:0]    d_rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic               l2_req_valid,
  input  logic               l2_req_ready,
  output logic [AW-1:0]      l2_addr,
  output logic               l2_write,
  output logic [DW-1:0]      l2_wdata,
  output logic [BEW-1:0]     l2_be,
  input  logic               l2_rsp_valid,
  input  logic [DW-1:0]      l2_rsp_rdata,
  output logic [NCPU-1:0]    snoop_valid,
  output logic [AW-1:0]      snoop_addr
);
  import cbarb_pkg::*;

  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1;

  arb_state_e     state;
  logic [IDW-1:0] ptr;
  logic [IDW-1:0] gnt_idx;
  logic           gnt_instr;

  logic           i_found, d_found;
  logic [IDW-1:0] i_pick, d_pick;
  logic           accept, snoop_fire;

  cbarb_rr_pick #(.NCPU(NCPU), .IDW(IDW)) u_ipick (
    .clk(clk), .rst_n(rst_n), .req(i_valid), .start(ptr),
    .found(i_found), .idx(i_pick));

  cbarb_rr_pick #(.NCPU(NCPU), .IDW(IDW)) u_dpick (
    .clk(clk), .rst_n(rst_n), .req(d_valid), .start(ptr),
    .found(d_found), .idx(d_pick));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      gnt_idx   <= '0;
      gnt_instr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (i_found || d_found) begin
          gnt_instr <= i_found;
          gnt_idx   <= i_found ? i_pick : d_pick;
          state     <= ST_ISSUE;
        end
        ST_ISSUE: if (l2_req_ready) state <= ST_WAIT;
        ST_WAIT: if (l2_rsp_valid) begin
          ptr   <= gnt_idx + IDW'(1);
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign l2_req_valid = (state == ST_ISSUE);
  assign accept       = l2_req_valid && l2_req_ready;

  cbarb_mux #(.NCPU(NCPU), .AW(AW), .DW(DW), .BEW(BEW), .IDW(IDW)) u_mux (
    .gnt_idx(gnt_idx), .gnt_instr(gnt_instr), .i_addr(i_addr),
    .d_write(d_write), .d_addr(d_addr), .d_wdata(d_wdata), .d_be(d_be),
    .addr(l2_addr), .write(l2_write), .wdata(l2_wdata), .be(l2_be));

  for (genvar c = 0; c < NCPU; c++) begin : g_route
    logic mine;
    assign mine           = (gnt_idx == IDW'(c));
    assign i_ready[c]     = accept && mine && gnt_instr;
    assign d_ready[c]     = accept && mine && !gnt_instr;
    assign i_rsp_valid[c] = (state == ST_WAIT) && l2_rsp_valid && mine && gnt_instr;
    assign d_rsp_valid[c] = (state == ST_WAIT) && l2_rsp_valid && mine && !gnt_instr;
  end

  assign rsp_rdata  = l2_rsp_rdata;
  assign snoop_fire = accept && !gnt_instr && l2_write;

  cbarb_snoop #(.NCPU(NCPU), .AW(AW), .IDW(IDW)) u_snoop (
    .clk(clk), .rst_n(rst_n), .fire(snoop_fire), .writer(gnt_idx),
    .addr(l2_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr));

  p_single_txn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !l2_req_valid);
  p_instr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && (|i_valid)) |=> gnt_instr);
  p_one_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i_ready, d_ready}));
  p_l2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_req_valid && !l2_req_ready) |=> (l2_req_valid && $stable(l2_addr) && $stable(l2_write)));
  p_one_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i_rsp_valid, d_rsp_valid}));
  p_snoop_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && l2_write) |=> (|snoop_valid || NCPU == 1));
endmodule

// File: tb/cbarb_top_test.sv
module cbarb_top_test;
  localparam int NCPU = 4;
  localparam int AW   = 32;
  localparam int DW   = 128;
  localparam int BEW  = DW / 8;
  localparam time TCLK = 10ns;
  localparam int NV   = 10;

  // Vector fields: {i_valid[3:0], d_valid[3:0], d_write[3:0], exp_instr, exp_cpu[1:0]}
  localparam logic [14:0] VEC [NV] = '{
    15'b0000_0001_0001_0_00,
    15'b0000_1111_0000_0_01,
    15'b0001_0100_0000_1_00,
    15'b1001_0000_0000_1_11,
    15'b0000_0110_0110_0_01,
    15'b1111_1111_0000_1_10,
    15'b0000_1001_1000_0_11,
    15'b0110_1111_1111_1_01,
    15'b0000_0011_0011_0_00,
    15'b0100_0000_0000_1_10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCPU-1:0] i_valid = '0, i_ready, d_valid = '0, d_ready, d_write = '0;
  logic [NCPU*AW-1:0] i_addr, d_addr;
  logic [NCPU*DW-1:0] d_wdata;
  logic [NCPU*BEW-1:0] d_be;
  logic [NCPU-1:0] i_rsp_valid, d_rsp_valid, snoop_valid;
  logic [DW-1:0] rsp_rdata, l2_wdata, l2_rsp_rdata = '0;
  logic l2_req_valid, l2_req_ready = 1'b0, l2_write, l2_rsp_valid = 1'b0;
  logic [AW-1:0] l2_addr, snoop_addr;
  logic [BEW-1:0] l2_be;

  int n_vec = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  cbarb_top #(.NCPU(NCPU), .AW(AW), .DW(DW), .BEW(BEW)) uut (
    .clk(clk), .rst_n(rst_n),
    .i_valid(i_valid), .i_ready(i_ready), .i_addr(i_addr),
    .d_valid(d_valid), .d_ready(d_ready), .d_write(d_write),
    .d_addr(d_addr), .d_wdata(d_wdata), .d_be(d_be),
    .i_rsp_valid(i_rsp_valid), .d_rsp_valid(d_rsp_valid), .rsp_rdata(rsp_rdata),
    .l2_req_valid(l2_req_valid), .l2_req_ready(l2_req_ready),
    .l2_addr(l2_addr), .l2_write(l2_write), .l2_wdata(l2_wdata), .l2_be(l2_be),
    .l2_rsp_valid(l2_rsp_valid), .l2_rsp_rdata(l2_rsp_rdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr));

  function automatic logic [AW-1:0] ia(int c);
    return 32'h1000_0000 + 32'(c) * 32'h100;
  endfunction
  function automatic logic [AW-1:0] da(int c);
    return 32'h8000_0010 + 32'(c) * 32'h100;
  endfunction
  function automatic logic [DW-1:0] wd(int c);
    return {4{32'hA500_0000 + 32'(c)}};
  endfunction
  function automatic logic [BEW-1:0] bb(int c);
    return 16'h0F00 | 16'(c + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // One transaction: drive requests, check the grant, stall, accept, snoop, respond.
  task automatic run_txn(input logic [3:0] im, input logic [3:0] dm, input logic [3:0] wm,
                         input bit ek, input int ec, input int stall, input int lat,
                         input bit intrude);
    logic [AW-1:0] ea;
    logic [NCPU-1:0] one, esn;
    bit ew;
    int k;
    ea  = ek ? ia(ec) : da(ec);
    ew  = !ek && wm[ec];
    one = NCPU'(1) << ec;
    esn = ew ? ~one : '0;
    @(negedge clk);
    i_valid = im; d_valid = dm; d_write = wm;
    @(negedge clk);
    k = 0;
    while (!l2_req_valid && k < 10) begin @(negedge clk); k++; end
    chk(l2_req_valid, "R3 request offered", DW'(l2_req_valid), 1);
    chk(l2_addr == ea, ek ? "R2/R3 fetch winner addr" : "R2/R3 data winner addr",
        DW'(l2_addr), DW'(ea));
    chk(l2_write == ew, "R6 write flag", DW'(l2_write), DW'(ew));
    if (!ek) begin
      chk(l2_wdata == wd(ec), "R6 wdata", l2_wdata, wd(ec));
      chk(l2_be == bb(ec), "R6 byte enables", DW'(l2_be), DW'(bb(ec)));
    end
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(l2_req_valid && l2_addr == ea, "R5 hold under stall", DW'(l2_addr), DW'(ea));
      chk({i_ready, d_ready} == '0, "R4 no ready while stalled",
          DW'({i_ready, d_ready}), 0);
    end
    l2_req_ready = 1'b1;
    #1;
    chk(i_ready == (ek ? one : '0) && d_ready == (ek ? '0 : one), "R4 ready to winner",
        DW'({i_ready, d_ready}), DW'(ek ? {one, 4'b0} : {4'b0, one}));
    @(negedge clk);
    l2_req_ready = 1'b0;
    i_valid = intrude ? 4'b0001 : '0;
    d_valid = '0;
    #1;
    chk(!l2_req_valid, "R1 quiet after accept", DW'(l2_req_valid), 0);
    chk(snoop_valid == esn, "R8 snoop mask", DW'(snoop_valid), DW'(esn));
    if (ew) chk(snoop_addr == ea, "R8 snoop addr", DW'(snoop_addr), DW'(ea));
    for (int s = 1; s < lat; s++) begin
      @(negedge clk);
      chk(!l2_req_valid && i_ready == '0, "R1 no new grant while busy",
          DW'(l2_req_valid), 0);
    end
    l2_rsp_valid = 1'b1;
    l2_rsp_rdata = {4{ea}};
    #1;
    chk(i_rsp_valid == (ek ? one : '0) && d_rsp_valid == (ek ? '0 : one), "R7 response route",
        DW'({i_rsp_valid, d_rsp_valid}), DW'(ek ? {one, 4'b0} : {4'b0, one}));
    chk(rsp_rdata == {4{ea}}, "R7 response data", rsp_rdata, {4{ea}});
    @(negedge clk);
    l2_rsp_valid = 1'b0;
    #1;
    chk(snoop_valid == '0, "R8 snoop one cycle", DW'(snoop_valid), 0);
  endtask

  initial begin
    for (int c = 0; c < NCPU; c++) begin
      i_addr[c*AW +: AW]   = ia(c);
      d_addr[c*AW +: AW]   = da(c);
      d_wdata[c*DW +: DW]  = wd(c);
      d_be[c*BEW +: BEW]   = bb(c);
    end
  end

  initial begin
    for (int t = 0; t < 20000; t++) @(posedge clk);
    n_bad++;
    n_vec++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    i_valid = 4'b1111; d_valid = 4'b1111;
    repeat (3) @(negedge clk);
    chk(!l2_req_valid && snoop_valid == '0 && {i_ready, d_ready} == '0,
        "R9 quiet in reset", DW'({l2_req_valid, snoop_valid}), 0);
    i_valid = '0; d_valid = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!l2_req_valid && {i_rsp_valid, d_rsp_valid} == '0, "R9 quiet after reset",
        DW'(l2_req_valid), 0);

    for (int v = 0; v < NV; v++) begin
      run_txn(VEC[v][14:11], VEC[v][10:7], VEC[v][6:3], VEC[v][2], int'(VEC[v][1:0]),
              v % 3, 1 + (v % 2), 1'b0);
    end

    // R1: fetch raised during an outstanding write waits; write keeps its response.
    run_txn(4'b0000, 4'b0100, 4'b0100, 1'b0, 2, 0, 3, 1'b1);
    run_txn(4'b0001, 4'b0000, 4'b0000, 1'b1, 0, 0, 1, 1'b0);

    // R9/R3: pointer back at CPU0 after reset.
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_txn(4'b0000, 4'b1111, 4'b0000, 1'b0, 0, 0, 2, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule